// File: doc/BRIEF.md
# NOR Flash Write-Command Sequence Decoder

This block is the write-side command interpreter of a 16-bit parallel NOR flash that uses the two-step unlock command protocol. It watches single-cycle bus writes, each carrying a word address and a data word. It recognises the multi-write sequences for identification, single-word programming, sector erase, whole-array erase and the fast "bypass" programming mode. It then drives a small on-chip word array, which is kept tiny so that it suits simulation. Commands travel in the low data byte. The command-address match looks only at the low address bits.

Reads are combinational. The `dev_mode` output reports one of three modes. In array mode, `rd_data` is the addressed word. In identification mode, the manufacturer and device codes appear at word addresses 0 and 1. In busy mode, `rd_data` reads zero for a fixed number of cycles after each program or erase. Programming can only clear bits. An erase sets every bit of the affected words.

The sequencer states are as follows. IDLE_READ is array read. UNLOCK_1 follows the first unlock write, and UNLOCK_2 follows the second. ERASE_ARM follows the erase-setup code. ERASE_UNLOCK_1 and ERASE_UNLOCK_2 are the second unlock pair. PROG_WAIT waits for the program data. ID_READ is identification. BYPASS is the bypass idle state, and BYPASS_PROG waits for bypass program data. BUSY runs the embedded-operation timer.

The transitions are as follows:
- IDLE_READ goes to UNLOCK_1 on 0xAA at 0x555.
- UNLOCK_1 goes to UNLOCK_2 on 0x55 at 0x2AA.
- From UNLOCK_2, the command written at 0x555 selects the next state: 0x90 goes to ID_READ, 0xA0 to PROG_WAIT, 0x80 to ERASE_ARM, and 0x20 to BYPASS.
- ERASE_ARM goes to ERASE_UNLOCK_1, and then ERASE_UNLOCK_2, by the same unlock pair.
- ERASE_UNLOCK_2 goes to BUSY on 0x30 at any address, which erases that sector. It also goes to BUSY on 0x10 at 0x555, which erases the whole array.
- PROG_WAIT and BYPASS_PROG go to BUSY on any write.
- BYPASS goes to BYPASS_PROG on 0xA0 at any address, and back to IDLE_READ on 0x00 or 0xF0.
- BUSY returns to BYPASS or IDLE_READ when the timer expires, or to IDLE_READ at once on 0xF0.
- Any unexpected write in a sequence state, and any write in ID_READ, returns to IDLE_READ.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset every array word reads 0xFFFF and `dev_mode` is 0 (array read).
- R2: The writes 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then data D at word address A, set word A to its old value AND D. Bits can only be cleared.
- R3: An unlock pair followed by 0x90 at 0x555 sets `dev_mode` to 1. In that mode, word address 0 reads 0x00BF, address 1 reads 0x236D and any other address reads 0x0000. Any write leaves the mode and returns to array read.
- R4: An unlock pair, 0x80 at 0x555, a second unlock pair, then 0x30 at any address, sets all 16 words of that address's sector to 0xFFFF. The sector is selected by word-address bits [5:4]. Other sectors keep their contents.
- R5: The same erase preamble followed by 0x10 at 0x555 sets every array word to 0xFFFF.
- R6: An unlock pair followed by 0x20 at 0x555 enters bypass. In bypass, 0xA0 at any address followed by a data write programs with AND semantics, and the decoder then returns to bypass. 0x00 or 0xF0 leaves bypass. After that, 0xA0 followed by data, with no unlock, changes nothing.
- R7: Command addresses are compared on word-address bits [10:0] only, so 0x5555 and 0x2AAA act as 0x555 and 0x2AA.
- R8: A write that breaks an expected sequence returns the decoder to array read and leaves the array unchanged.
- R9: After a program or erase is accepted, `dev_mode` is 2 and `rd_data` is 0x0000. This lasts exactly 4 cycles for a program and 16 cycles for an erase. Writes other than 0xF0 during that time are ignored.
- R10: 0xF0 written at any address returns the decoder to array read. During busy this takes effect on the next cycle, and in a sequence state it discards the partial sequence.
- R11: Only the low data byte is compared as a command code; the upper byte of a command write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 16 | Word address of the write |
| bus_wdata | input | 16 | Write data; command code in bits [7:0] |
| rd_addr | input | 16 | Word address for reads |
| rd_data | output | 16 | Read data: array word, ID code, or zero while busy |
| dev_mode | output | 2 | 0 array read, 1 identification, 2 busy |

## Verification
A sequencer stuck in the wrong state shows up on the first read after the next command. Either `dev_mode` reports the wrong mode, or an array word fails to take a program or erase, or takes one it should not. The bench therefore reads back the whole array after every pass, so a stray write lands on a compared word at once. A wrong busy timer shows as a busy window one or more cycles off from 4 or 16, which the bench counts directly. A wrong bypass or abort path is caught on the following read, which sees either a word that changed when it should not have or a mode that did not return to 0.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        S_IDLE_READ,
        S_UNLOCK_1,
        S_UNLOCK_2,
        S_ERASE_ARM,
        S_ERASE_UNLOCK_1,
        S_ERASE_UNLOCK_2,
        S_PROG_WAIT,
        S_ID_READ,
        S_BYPASS,
        S_BYPASS_PROG,
        S_BUSY
    } fcd_state_e;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_ID    = 2'd1,
        MODE_BUSY  = 2'd2
    } fcd_mode_e;

    localparam logic [7:0] CMD_KEY_A      = 8'hAA;
    localparam logic [7:0] CMD_KEY_B      = 8'h55;
    localparam logic [7:0] CMD_IDENT      = 8'h90;
    localparam logic [7:0] CMD_WRITE      = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SET  = 8'h80;
    localparam logic [7:0] CMD_SECTOR     = 8'h30;
    localparam logic [7:0] CMD_WHOLE      = 8'h10;
    localparam logic [7:0] CMD_BYP_ENTER  = 8'h20;
    localparam logic [7:0] CMD_BYP_LEAVE  = 8'h00;
    localparam logic [7:0] CMD_ABORT      = 8'hF0;

    localparam logic [15:0] CODE_MAKER  = 16'h00BF;
    localparam logic [15:0] CODE_DEVICE = 16'h236D;

    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
    parameter int CMD_AW = 11
) (
    input  logic [CMD_AW-1:0] addr_lo,
    output logic              hit_a,
    output logic              hit_b
);
    import fcd_pkg::*;

    localparam logic [CMD_AW-1:0] MATCH_A = CMD_AW'(KEY_ADDR_A);
    localparam logic [CMD_AW-1:0] MATCH_B = CMD_AW'(KEY_ADDR_B);

    always_comb begin
        hit_a = (addr_lo == MATCH_A);
        hit_b = (addr_lo == MATCH_B);
    end
endmodule

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer #(
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    input  logic abort,
    output logic done
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_PROG  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] LOAD_ERASE = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (start_erase) begin
            cnt_q <= LOAD_ERASE;
        end else if (start_prog) begin
            cnt_q <= LOAD_PROG;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fcd_array.sv
module fcd_array #(
    parameter int WORDS        = 64,
    parameter int SECTOR_WORDS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_en,
    input  logic [$clog2(WORDS)-1:0] prog_idx,
    input  logic [15:0]              prog_data,
    input  logic                     sect_erase,
    input  logic [$clog2(WORDS)-1:0] erase_idx,
    input  logic                     chip_erase,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [15:0]              rd_word
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int OFS_W = $clog2(SECTOR_WORDS);
    localparam int SEC_W = IDX_W - OFS_W;

    logic [15:0]      cell_q [WORDS];
    logic [SEC_W-1:0] erase_sec;

    assign erase_sec = erase_idx[IDX_W-1:OFS_W];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(gi / SECTOR_WORDS);
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
        logic wipe;
        logic hit;
        assign wipe = chip_erase | (sect_erase & (erase_sec == MY_SEC));
        assign hit  = prog_en & (prog_idx == MY_IDX);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q[gi] <= '1;
            end else if (wipe) begin
                cell_q[gi] <= '1;
            end else if (hit) begin
                cell_q[gi] <= cell_q[gi] & prog_data;
            end
        end
    end

    assign rd_word = cell_q[rd_idx];
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               cmd,
    input  logic                     hit_a,
    input  logic                     hit_b,
    input  logic                     tmr_done,
    output fcd_pkg::fcd_state_e      state,
    output logic                     prog_en,
    output logic                     sect_erase,
    output logic                     chip_erase,
    output logic                     abort
);
    import fcd_pkg::*;

    fcd_state_e state_q, state_d;
    logic       byp_q, byp_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE_READ;
            byp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            byp_q   <= byp_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        byp_d   = byp_q;
        unique case (state_q)
            S_IDLE_READ: begin
                if (wr_en && hit_a && cmd == CMD_KEY_A) state_d = S_UNLOCK_1;
            end
            S_UNLOCK_1: begin
                if (wr_en) state_d = (hit_b && cmd == CMD_KEY_B) ? S_UNLOCK_2 : S_IDLE_READ;
            end
            S_UNLOCK_2: begin
                if (wr_en) begin
                    if (hit_a && cmd == CMD_IDENT)          state_d = S_ID_READ;
                    else if (hit_a && cmd == CMD_WRITE)     state_d = S_PROG_WAIT;
                    else if (hit_a && cmd == CMD_ERASE_SET) state_d = S_ERASE_ARM;
                    else if (hit_a && cmd == CMD_BYP_ENTER) state_d = S_BYPASS;
                    else                                    state_d = S_IDLE_READ;
                end
            end
            S_ERASE_ARM: begin
                if (wr_en) state_d = (hit_a && cmd == CMD_KEY_A) ? S_ERASE_UNLOCK_1 : S_IDLE_READ;
            end
            S_ERASE_UNLOCK_1: begin
                if (wr_en) state_d = (hit_b && cmd == CMD_KEY_B) ? S_ERASE_UNLOCK_2 : S_IDLE_READ;
            end
            S_ERASE_UNLOCK_2: begin
                if (wr_en) begin
                    if (cmd == CMD_SECTOR || (hit_a && cmd == CMD_WHOLE)) begin
                        state_d = S_BUSY;
                        byp_d   = 1'b0;
                    end else begin
                        state_d = S_IDLE_READ;
                    end
                end
            end
            S_PROG_WAIT: begin
                if (wr_en) begin
                    state_d = S_BUSY;
                    byp_d   = 1'b0;
                end
            end
            S_ID_READ: begin
                if (wr_en) state_d = S_IDLE_READ;
            end
            S_BYPASS: begin
                if (wr_en) begin
                    if (cmd == CMD_WRITE) state_d = S_BYPASS_PROG;
                    else if (cmd == CMD_BYP_LEAVE || cmd == CMD_ABORT) state_d = S_IDLE_READ;
                end
            end
            S_BYPASS_PROG: begin
                if (wr_en) begin
                    state_d = S_BUSY;
                    byp_d   = 1'b1;
                end
            end
            S_BUSY: begin
                if (wr_en && cmd == CMD_ABORT) begin
                    state_d = S_IDLE_READ;
                    byp_d   = 1'b0;
                end else if (tmr_done) begin
                    state_d = byp_q ? S_BYPASS : S_IDLE_READ;
                end
            end
            default: state_d = S_IDLE_READ;
        endcase
    end

    // action outputs
    always_comb begin
        prog_en    = 1'b0;
        sect_erase = 1'b0;
        chip_erase = 1'b0;
        abort      = 1'b0;
        unique case (state_q)
            S_PROG_WAIT, S_BYPASS_PROG: prog_en = wr_en;
            S_ERASE_UNLOCK_2: begin
                sect_erase = wr_en && cmd == CMD_SECTOR;
                chip_erase = wr_en && hit_a && cmd == CMD_WHOLE;
            end
            S_BUSY: abort = wr_en && cmd == CMD_ABORT;
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
    parameter int BUS_AW       = 16,
    parameter int CMD_AW       = 11,
    parameter int WORDS        = 64,
    parameter int SECTOR_WORDS = 16,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [BUS_AW-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic [1:0]        dev_mode
);
    import fcd_pkg::*;

    localparam int IDX_W = $clog2(WORDS);

    logic       hit_a, hit_b;
    logic       tmr_done;
    logic       prog_en, sect_erase, chip_erase, abort;
    logic [15:0] arr_word;
    fcd_state_e fsm_state;

    fcd_addr_match #(.CMD_AW(CMD_AW)) u_match (
        .addr_lo (bus_addr[CMD_AW-1:0]),
        .hit_a   (hit_a),
        .hit_b   (hit_b)
    );

    fcd_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we),
        .cmd        (bus_wdata[7:0]),
        .hit_a      (hit_a),
        .hit_b      (hit_b),
        .tmr_done   (tmr_done),
        .state      (fsm_state),
        .prog_en    (prog_en),
        .sect_erase (sect_erase),
        .chip_erase (chip_erase),
        .abort      (abort)
    );

    fcd_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (prog_en),
        .start_erase (sect_erase | chip_erase),
        .abort       (abort),
        .done        (tmr_done)
    );

    fcd_array #(
        .WORDS        (WORDS),
        .SECTOR_WORDS (SECTOR_WORDS)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_en),
        .prog_idx   (bus_addr[IDX_W-1:0]),
        .prog_data  (bus_wdata),
        .sect_erase (sect_erase),
        .erase_idx  (bus_addr[IDX_W-1:0]),
        .chip_erase (chip_erase),
        .rd_idx     (rd_addr[IDX_W-1:0]),
        .rd_word    (arr_word)
    );

    // output decode
    always_comb begin
        unique case (fsm_state)
            S_BUSY: begin
                dev_mode = MODE_BUSY;
                rd_data  = '0;
            end
            S_ID_READ: begin
                dev_mode = MODE_ID;
                if (rd_addr == BUS_AW'(0))      rd_data = CODE_MAKER;
                else if (rd_addr == BUS_AW'(1)) rd_data = CODE_DEVICE;
                else                            rd_data = '0;
            end
            default: begin
                dev_mode = MODE_ARRAY;
                rd_data  = arr_word;
            end
        endcase
    end
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int BUS_AW = 16,
    parameter int CMD_AW = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [BUS_AW-1:0]   bus_addr,
    input logic [15:0]         bus_wdata,
    input logic [BUS_AW-1:0]   rd_addr,
    input logic [15:0]         rd_data,
    input logic [1:0]          dev_mode,
    input fcd_pkg::fcd_state_e fsm_state,
    input logic                tmr_done
);
    import fcd_pkg::*;

    logic key_b_here;
    assign key_b_here = (bus_addr[CMD_AW-1:0] == CMD_AW'(12'h2AA)) && (bus_wdata[7:0] == 8'h55);

    assert_prog_to_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_PROG_WAIT && bus_we) |=> dev_mode == 2'd2);

    assert_maker_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode == 2'd1 && rd_addr == '0) |-> rd_data == 16'h00BF);

    assert_broken_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_UNLOCK_1 && bus_we && !key_b_here) |=> fsm_state == S_IDLE_READ);

    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_mode == 2'd2 |-> rd_data == 16'h0000);

    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_mode != 2'd3);

    assert_busy_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode != 2'd2 && $past(dev_mode) == 2'd2) |->
            ($past(tmr_done) || ($past(bus_we) && $past(bus_wdata[7:0]) == 8'hF0)));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode == 2'd2 && bus_we && bus_wdata[7:0] == 8'hF0) |=> dev_mode == 2'd0);

endmodule

bind nor_cmd_decoder fcd_checker #(.BUS_AW(BUS_AW), .CMD_AW(CMD_AW)) u_fcd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .dev_mode  (dev_mode),
    .fsm_state (fsm_state),
    .tmr_done  (tmr_done)
);

// File: tb/tb_nor_cmd_decoder.sv
module tb_nor_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;
    localparam int SECW       = 16;
    localparam int PROG_N     = 4;
    localparam int ERASE_N    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  dev_mode;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] model [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data), .dev_mode(dev_mode)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic peek(input logic [15:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic unlock();
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (dev_mode == 2'd2 && n < 1000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic sweep(input string req);
        logic [15:0] v;
        for (int i = 0; i < WORDS; i++) begin
            peek(16'(i), v);
            check(req, v, model[i]);
        end
    endtask

    task automatic program_word(input logic [15:0] a, input logic [15:0] d);
        int n;
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(a, d);
        wait_ready(n);
        model[a[5:0]] = model[a[5:0]] & d;
    endtask

    task automatic erase_start(input logic [15:0] a);
        unlock();
        wr(16'h0555, 16'h0080);
        unlock();
        wr(a, 16'h0030);
        for (int i = 0; i < SECW; i++) model[(a[5:4] * SECW) + i] = 16'hFFFF;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] v;
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        check("R1 mode", {14'd0, dev_mode}, 16'd0);
        sweep("R1 erased");

        // R2 AND programming, two passes over every word
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(16'h0000, 16'h0055);
        wait_ready(n);
        check("R9 prog busy length", 16'(n), 16'(PROG_N));
        model[0] = 16'h0055;
        program_word(16'h0000, 16'h00A5);
        peek(16'h0000, v);
        check("R2 55 then A5", v, 16'h0005);
        for (int i = 1; i < WORDS; i++) program_word(16'(i), 16'(i * 16'h9E37) ^ 16'h5A5A);
        for (int i = 1; i < WORDS; i++) program_word(16'(i), ~16'(i * 16'h0313));
        sweep("R2 and program");

        // R4 sector erase of each sector, others intact
        for (int s = 0; s < 4; s++) begin
            erase_start(16'(s * SECW + 3));
            wait_ready(n);
            if (s == 0) check("R9 erase busy length", 16'(n), 16'(ERASE_N));
            sweep("R4 sector erase");
            for (int i = s * SECW; i < s * SECW + SECW; i++) program_word(16'(i), 16'(i * 16'h0101));
        end

        // R5 chip erase
        unlock();
        wr(16'h0555, 16'h0080);
        unlock();
        wr(16'h0555, 16'h0010);
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        check("R9 busy mode", {14'd0, dev_mode}, 16'd2);
        peek(16'h0000, v);
        check("R9 busy reads zero", v, 16'h0000);
        wait_ready(n);
        check("R5 erase length", 16'(n), 16'(ERASE_N));
        sweep("R5 chip erase");

        // R3 identification
        unlock();
        wr(16'h0555, 16'h0090);
        check("R3 mode", {14'd0, dev_mode}, 16'd1);
        peek(16'h0000, v); check("R3 maker", v, 16'h00BF);
        peek(16'h0001, v); check("R3 device", v, 16'h236D);
        peek(16'h0002, v); check("R3 other", v, 16'h0000);
        peek(16'h0041, v); check("R3 high other", v, 16'h0000);
        wr(16'h0000, 16'h00F0);
        check("R3 exit", {14'd0, dev_mode}, 16'd0);

        // R7 upper address bits, R11 upper data byte
        wr(16'h5555, 16'h33AA);
        wr(16'h2AAA, 16'h4455);
        wr(16'hD555, 16'hC390);
        check("R7 R11 wide unlock", {14'd0, dev_mode}, 16'd1);
        peek(16'h0001, v); check("R7 device", v, 16'h236D);
        wr(16'h0003, 16'h1234);
        check("R3 any write exits", {14'd0, dev_mode}, 16'd0);

        // R6 bypass
        unlock();
        wr(16'h0555, 16'h0020);
        check("R6 bypass mode", {14'd0, dev_mode}, 16'd0);
        wr(16'h0003, 16'h00A0); wr(16'h0000, 16'h0123); wait_ready(n);
        wr(16'h1234, 16'h00A0); wr(16'h0001, 16'h4567); wait_ready(n);
        wr(16'h0000, 16'h00A0); wr(16'h0002, 16'h89AB); wait_ready(n);
        model[0] = 16'h0123; model[1] = 16'h4567; model[2] = 16'h89AB;
        wr(16'h0000, 16'h0000);
        wr(16'h0555, 16'h00A0);
        wr(16'h0004, 16'h0089);
        check("R6 after exit mode", {14'd0, dev_mode}, 16'd0);
        sweep("R6 bypass");

        // R8 broken sequences
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0012);
        wr(16'h0555, 16'h00A0);
        wr(16'h0008, 16'h0000);
        unlock();
        wr(16'h0555, 16'h0077);
        wr(16'h0009, 16'h0000);
        unlock();
        wr(16'h0555, 16'h0080);
        wr(16'h0555, 16'h0011);
        wr(16'h0010, 16'h0030);
        check("R8 mode", {14'd0, dev_mode}, 16'd0);
        sweep("R8 unchanged");

        // R9 writes during busy are ignored
        program_word(16'h0028, 16'h0F0F);
        erase_start(16'h0005);
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
        wr(16'h0555, 16'h00A0);
        wr(16'h0028, 16'h0000);
        wait_ready(n);
        check("R9 mode after", {14'd0, dev_mode}, 16'd0);
        sweep("R9 busy ignore");

        // R10 abort during busy and inside a sequence
        program_word(16'h0010, 16'h0000);
        erase_start(16'h0012);
        wr(16'h1234, 16'h00F0);
        check("R10 abort busy", {14'd0, dev_mode}, 16'd0);
        unlock();
        wr(16'h0007, 16'h00F0);
        wr(16'h0555, 16'h00A0);
        wr(16'h0005, 16'h0000);
        sweep("R10 abort");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule